// File: doc/BRIEF.md
# Serial Three-Wire EEPROM Word Access Controller

This block sits between a byte-wide host register port and a serial EEPROM that stores 16-bit words over a three-wire synchronous link (chip select, serial clock, data out to the device, data in from the device). Software loads a word address and, for writes, two data bytes. It then writes a command code to the control register. The controller builds the serial instruction, shifts it out, collects read data, and for writes polls the device until it reports ready. Busy and error flags are reported in the status byte.

The lowest word addresses form a factory area. A write command aimed there is refused in hardware unless the factory jumper input is high. A refused write raises a write-error flag and produces no serial activity. The data byte registers feed the outgoing word only. A read of those offsets returns the word from the last EEPROM read, never the bytes just written.

Top module: `uwire_eeprom_ctrl`

## Requirements
- R1: After reset the status byte, both data bytes and the word address read 0, and `ee_cs`, `ee_sk` and `ee_di` are low.
- R2: Writing 0x01 to offset 0 issues the enable-write instruction. It is a start bit 1, opcode 00, then an address field whose two leading bits are 11 and the rest 0, for ADDR_W+3 clocked bits in total.
- R3: Writing 0x02 to offset 0 issues a read: start bit 1, opcode 10, the word address MSB first. The controller then clocks 17 more bits and drops the first, which is the device's dummy 0. The remaining 16 bits are taken MSB first and appear at offset 1 (low byte) and offset 2 (high byte) once busy clears.
- R4: Writing 0x03 to offset 0 issues a write: start bit 1, opcode 01, the word address, then the 16-bit word MSB first. The high byte comes from offset 2 and the low byte from offset 1. The word address is taken from offset 3.
- R5: A write command to a word address below FACT_WORDS (16) while `fact_jmp` is low produces no chip-select activity and sets status bit 1 (WERR) on the next cycle. At address 16, or with the jumper high, the write proceeds.
- R6: WERR (status bit 1) and TERR (status bit 2) clear when the next accepted command starts.
- R7: Status bit 0 (BUSY) is 1 from the cycle after an accepted command until the closing chip-select gap ends. Commands written while BUSY is 1 are ignored.
- R8: After a write frame, chip select drops for two SK half-periods and then rises again. BUSY holds until the device drives `ee_do` high. If that does not happen within TMO_TICKS half-periods, TERR (status bit 2) is set.
- R9: Every change of `ee_cs` or `ee_sk` is at least DIV clocks after the previous change. `ee_sk` is low whenever `ee_cs` is low. Chip select stays low for at least 2*DIV clocks before any rise.
- R10: Reading offsets 1 and 2 returns the last read word, not the values written there.
- R11: Status bits 7..3 read 0. Command codes other than 0x01..0x03 start nothing and change no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register offset: 0 control/status, 1 data low, 2 data high, 3 word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| fact_jmp | input | 1 | Factory jumper; high permits writes to the factory area |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data and ready indication from the EEPROM |

## Verification
A behavioural EEPROM in the bench decodes every frame from the serial lines and serves read data. Reads of words with asymmetric patterns (0x1234, 0xA55A, 0x8001) show whether bit order and byte placement are correct. Writes near the factory boundary (0x0F blocked and 0x10 allowed with the jumper low, 0x05 allowed with it high) separate the guard's comparison from its jumper term. A device that never becomes ready, compared with one that becomes ready after a few cycles, separates the timeout path from the normal poll. Commands issued while busy and unknown command codes show up as extra or missing decoded frames.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

    // register offsets
    localparam logic [1:0] OFF_CTRL  = 2'd0;
    localparam logic [1:0] OFF_DLO   = 2'd1;
    localparam logic [1:0] OFF_DHI   = 2'd2;
    localparam logic [1:0] OFF_WADDR = 2'd3;

    // command codes written to the control offset
    localparam logic [7:0] CMD_EWEN  = 8'h01;
    localparam logic [7:0] CMD_READ  = 8'h02;
    localparam logic [7:0] CMD_WRITE = 8'h03;

    // serial opcodes following the start bit
    typedef enum logic [1:0] {
        OP_EWEN  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } uw_op_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SHIFT,
        SQ_GAP_PRE,
        SQ_POLL,
        SQ_GAP_END
    } sq_state_e;

    typedef struct packed {
        logic terr;
        logic werr;
        logic busy;
    } uw_status_t;

    function automatic logic [7:0] status_byte(uw_status_t s);
        return {5'b0, s};
    endfunction

    function automatic logic cmd_valid(logic [7:0] c);
        return (c == CMD_EWEN) || (c == CMD_READ) || (c == CMD_WRITE);
    endfunction

    function automatic uw_op_e cmd_to_op(logic [7:0] c);
        case (c)
            CMD_READ:  return OP_READ;
            CMD_WRITE: return OP_WRITE;
            default:   return OP_EWEN;
        endcase
    endfunction

endpackage

// File: rtl/uwire_tick.sv
module uwire_tick #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV < 2) ? 1 : $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)        cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/uwire_guard.sv
module uwire_guard #(
    parameter int ADDR_W     = 6,
    parameter int FACT_WORDS = 16
) (
    input  logic              is_write,
    input  logic              jumper,
    input  logic [ADDR_W-1:0] word_addr,
    output logic              blocked
);
    generate
        if (FACT_WORDS == 0) begin : g_open
            logic unused_in;
            assign unused_in = is_write ^ jumper ^ (^word_addr);
            assign blocked   = 1'b0;
        end else begin : g_fence
            localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(FACT_WORDS);
            assign blocked = is_write && !jumper && ({1'b0, word_addr} < LIMIT);
        end
    endgenerate
endmodule

// File: rtl/uwire_seq.sv
module uwire_seq
    import uwire_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int TMO_TICKS = 20000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  uw_op_e            op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              tick,
    input  logic              ee_do,
    output logic              busy,
    output logic [15:0]       rd_word,
    output logic              terr_pulse,
    output logic              cs,
    output logic              sk,
    output logic              di
);
    localparam int HDR = 3 + ADDR_W;
    localparam int FW  = HDR + 16;
    localparam int IW  = $clog2(FW + 1);
    localparam int TW  = $clog2(TMO_TICKS + 1);
    localparam logic [IW-1:0] RX_FIRST = IW'(HDR);
    localparam logic [TW-1:0] TMO_LAST = TW'(TMO_TICKS - 1);

    sq_state_e        state;
    uw_op_e           op_q;
    logic [FW-1:0]    frame_q, frame_new;
    logic [IW-1:0]    idx, last_idx;
    logic [15:0]      rx;
    logic             gcnt;
    logic [TW-1:0]    tmo;

    always_comb begin
        case (op)
            OP_WRITE: frame_new = {1'b1, OP_WRITE, addr, wdata};
            OP_READ:  frame_new = {1'b1, OP_READ, addr, 16'h0};
            default:  frame_new = {1'b1, OP_EWEN, 2'b11, {(ADDR_W-2){1'b0}}, 16'h0};
        endcase
    end

    always_comb begin
        case (op_q)
            OP_WRITE: last_idx = IW'(HDR + 15);
            OP_READ:  last_idx = IW'(HDR + 16);
            default:  last_idx = IW'(HDR - 1);
        endcase
    end

    assign busy = (state != SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_IDLE;
            op_q       <= OP_EWEN;
            frame_q    <= '0;
            idx        <= '0;
            rx         <= '0;
            gcnt       <= 1'b0;
            tmo        <= '0;
            rd_word    <= '0;
            terr_pulse <= 1'b0;
            cs         <= 1'b0;
            sk         <= 1'b0;
            di         <= 1'b0;
        end else begin
            terr_pulse <= 1'b0;
            case (state)
                SQ_IDLE: if (start) begin
                    frame_q <= frame_new;
                    op_q    <= op;
                    idx     <= '0;
                    cs      <= 1'b1;
                    sk      <= 1'b0;
                    di      <= frame_new[FW-1];
                    state   <= SQ_SHIFT;
                end
                SQ_SHIFT: if (tick) begin
                    if (!sk) begin
                        sk <= 1'b1;
                        if (op_q == OP_READ && idx >= RX_FIRST)
                            rx <= {rx[14:0], ee_do};
                    end else begin
                        sk <= 1'b0;
                        if (idx == last_idx) begin
                            cs   <= 1'b0;
                            di   <= 1'b0;
                            gcnt <= 1'b0;
                            if (op_q == OP_READ) rd_word <= rx;
                            state <= (op_q == OP_WRITE) ? SQ_GAP_PRE : SQ_GAP_END;
                        end else begin
                            idx     <= idx + 1'b1;
                            frame_q <= {frame_q[FW-2:0], 1'b0};
                            di      <= frame_q[FW-2];
                        end
                    end
                end
                SQ_GAP_PRE: if (tick) begin
                    if (gcnt) begin
                        cs    <= 1'b1;
                        tmo   <= '0;
                        state <= SQ_POLL;
                    end else gcnt <= 1'b1;
                end
                SQ_POLL: if (tick) begin
                    if (ee_do) begin
                        cs    <= 1'b0;
                        gcnt  <= 1'b0;
                        state <= SQ_GAP_END;
                    end else if (tmo == TMO_LAST) begin
                        terr_pulse <= 1'b1;
                        cs         <= 1'b0;
                        gcnt       <= 1'b0;
                        state      <= SQ_GAP_END;
                    end else tmo <= tmo + 1'b1;
                end
                SQ_GAP_END: if (tick) begin
                    if (gcnt) state <= SQ_IDLE;
                    else      gcnt  <= 1'b1;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uwire_eeprom_ctrl.sv
module uwire_eeprom_ctrl
    import uwire_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DIV        = 50,
    parameter int TMO_TICKS  = 20000,
    parameter int FACT_WORDS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       fact_jmp,
    output logic       ee_cs,
    output logic       ee_sk,
    output logic       ee_di,
    input  logic       ee_do
);
    logic [15:0]       wr_word;
    logic [ADDR_W-1:0] waddr;
    logic              werr, terr;
    logic              busy, tick, terr_pulse, blocked;
    logic              ctrl_wr, cmd_ok, start, prot_hit;
    logic [15:0]       seq_rd;
    uw_op_e            req_op;
    uw_status_t        stat;

    assign ctrl_wr  = reg_wr && (reg_addr == OFF_CTRL);
    assign cmd_ok   = cmd_valid(reg_wdata);
    assign req_op   = cmd_to_op(reg_wdata);
    assign prot_hit = ctrl_wr && !busy && cmd_ok && blocked;
    assign start    = ctrl_wr && !busy && cmd_ok && !blocked;

    uwire_guard #(.ADDR_W(ADDR_W), .FACT_WORDS(FACT_WORDS)) u_guard (
        .is_write  (cmd_ok && (req_op == OP_WRITE)),
        .jumper    (fact_jmp),
        .word_addr (waddr),
        .blocked   (blocked)
    );

    uwire_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (busy),
        .tick (tick)
    );

    uwire_seq #(.ADDR_W(ADDR_W), .TMO_TICKS(TMO_TICKS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .op         (req_op),
        .addr       (waddr),
        .wdata      (wr_word),
        .tick       (tick),
        .ee_do      (ee_do),
        .busy       (busy),
        .rd_word    (seq_rd),
        .terr_pulse (terr_pulse),
        .cs         (ee_cs),
        .sk         (ee_sk),
        .di         (ee_di)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_word <= '0;
            waddr   <= '0;
            werr    <= 1'b0;
            terr    <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == OFF_DLO)   wr_word[7:0]  <= reg_wdata;
            if (reg_wr && reg_addr == OFF_DHI)   wr_word[15:8] <= reg_wdata;
            if (reg_wr && reg_addr == OFF_WADDR) waddr <= reg_wdata[ADDR_W-1:0];
            if (start)         werr <= 1'b0;
            else if (prot_hit) werr <= 1'b1;
            if (start)           terr <= 1'b0;
            else if (terr_pulse) terr <= 1'b1;
        end
    end

    assign stat = '{terr: terr, werr: werr, busy: busy};

    always_comb begin
        case (reg_addr)
            OFF_CTRL: reg_rdata = status_byte(stat);
            OFF_DLO:  reg_rdata = seq_rd[7:0];
            OFF_DHI:  reg_rdata = seq_rd[15:8];
            default:  reg_rdata = 8'(waddr);
        endcase
    end
endmodule

// File: rtl/uwire_chk.sv
module uwire_chk (
    input logic        clk,
    input logic        rst,
    input logic        ee_cs,
    input logic        ee_sk,
    input logic        busy,
    input logic        werr,
    input logic        prot_hit,
    input logic [15:0] seq_rd
);
    assert_sk_low_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !ee_cs |-> !ee_sk);

    assert_cs_within_busy_R7: assert property (@(posedge clk) disable iff (rst)
        ee_cs |-> busy);

    assert_fence_refuses_R5: assert property (@(posedge clk) disable iff (rst)
        prot_hit |=> (werr && !busy && !ee_cs));

    assert_start_clears_werr_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !werr);

    assert_read_word_held_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> $stable(seq_rd));
endmodule

bind uwire_eeprom_ctrl uwire_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .ee_cs    (ee_cs),
    .ee_sk    (ee_sk),
    .busy     (busy),
    .werr     (werr),
    .prot_hit (prot_hit),
    .seq_rd   (seq_rd)
);

// File: tb/test_uwire_eeprom_ctrl.sv
module test_uwire_eeprom_ctrl;
    localparam int DIV = 2;
    localparam int AW  = 6;
    localparam int H   = 3 + AW;

    logic       clk = 0, rst = 1;
    logic [1:0] reg_addr = 0;
    logic       reg_wr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       fact_jmp = 0;
    logic       ee_cs, ee_sk, ee_di;
    logic       do_drv = 0;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    uwire_eeprom_ctrl #(.ADDR_W(AW), .DIV(DIV), .TMO_TICKS(20), .FACT_WORDS(16)) i_uwire_eeprom_ctrl (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fact_jmp(fact_jmp), .ee_cs(ee_cs), .ee_sk(ee_sk),
        .ee_di(ee_di), .ee_do(do_drv));

    // ---------------- behavioural EEPROM ----------------
    logic [15:0] mem [64];
    logic [31:0] hdr = 0;
    int   nb = 0, frame_cnt = 0, last_nb = 0, rdy_dly = 5;
    bit   poll_mode = 0, prog_pending = 0, ew_on = 0;
    logic [1:0] cur_op = 0, last_op = 0;
    logic [5:0] cur_addr = 0, last_addr = 0;
    logic cur_start = 0, last_start = 0;

    always @(posedge ee_cs) begin
        if (prog_pending) begin
            prog_pending = 0;
            poll_mode = 1;
            do_drv = 0;
            fork
                begin
                    repeat (rdy_dly) @(posedge clk);
                    if (poll_mode) do_drv = 1;
                end
            join_none
        end else begin
            nb = 0;
            hdr = 0;
        end
    end

    always @(posedge ee_sk) if (ee_cs && !poll_mode) begin
        hdr = {hdr[30:0], ee_di};
        nb++;
        if (nb == H) begin
            cur_start = hdr[8];
            cur_op    = hdr[7:6];
            cur_addr  = hdr[5:0];
        end
    end

    always @(negedge ee_sk) if (ee_cs && !poll_mode && nb >= H && cur_op == 2'b10) begin
        if (nb == H) do_drv = 0;
        else if (nb - H <= 16) do_drv = mem[cur_addr][16 - (nb - H)];
    end

    always @(negedge ee_cs) begin
        if (poll_mode) begin
            poll_mode = 0;
            do_drv = 0;
        end else begin
            frame_cnt++;
            last_nb = nb; last_op = cur_op; last_addr = cur_addr; last_start = cur_start;
            do_drv = 0;
            if (cur_op == 2'b00 && cur_addr[5:4] == 2'b11) ew_on = 1;
            if (cur_op == 2'b01 && nb == H + 16 && ew_on) begin
                mem[cur_addr] = hdr[15:0];
                prog_pending = 1;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd_reg(2'd0, s);
            if (s[0] == 1'b0) break;
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // ---------------- per-clock serial timing reference (R9) ----------------
    int   since = 100, cs_low = 100;
    logic pcs = 0, psk = 0;
    always @(negedge clk) if (!rst) begin
        if (ee_cs !== pcs || ee_sk !== psk) begin
            chk("R9 edge spacing", (since >= DIV), 1);
            since = 1;
        end else since++;
        if (ee_cs && !pcs) chk("R9 cs low gap", (cs_low >= 2*DIV), 1);
        if (!ee_cs) cs_low++; else cs_low = 0;
        if (!ee_cs && ee_sk) chk("R9 sk while cs low", 1, 0);
        pcs = ee_cs; psk = ee_sk;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] v, lo, hi;
        int fc;
        for (int i = 0; i < 64; i++) mem[i] = 16'h0;
        mem[7]    = 16'hA55A;
        mem[6'h3F] = 16'h8001;
        mem[6'h0F] = 16'hBEEF;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1 reset state
        rd_reg(0, v); chk("R1 status", v, 0);
        rd_reg(1, v); chk("R1 data lo", v, 0);
        rd_reg(2, v); chk("R1 data hi", v, 0);
        rd_reg(3, v); chk("R1 waddr", v, 0);
        chk("R1 serial lines", {ee_cs, ee_sk, ee_di}, 0);

        // R2 enable-write frame
        wr_reg(0, 8'h01);
        rd_reg(0, v); chk("R7 busy after cmd", v, 8'h01);
        wait_idle();
        chk("R2 frame bits", last_nb, H);
        chk("R2 start+op", {last_start, last_op}, 3'b100);
        chk("R2 addr field", last_addr, 6'b110000);

        // R4 write, R7 ignored command while busy, R10 write-through
        fact_jmp = 0;
        wr_reg(1, 8'h34); wr_reg(2, 8'h12);
        rd_reg(1, v); chk("R10 data lo not readback", v, 0);
        rd_reg(2, v); chk("R10 data hi not readback", v, 0);
        wr_reg(3, 8'h25);
        rd_reg(3, v); chk("R4 waddr readback", v, 8'h25);
        fc = frame_cnt;
        wr_reg(0, 8'h03);
        wr_reg(0, 8'h02);
        wait_idle();
        chk("R7 busy ignores cmd", frame_cnt - fc, 1);
        chk("R4 op", {last_start, last_op}, 3'b101);
        chk("R4 frame bits", last_nb, H + 16);
        chk("R4 stored word", mem[6'h25], 16'h1234);
        rd_reg(0, v); chk("R8 ready status", v, 0);

        // R3 reads with distinct patterns
        wr_reg(0, 8'h02);
        wait_idle();
        rd_reg(1, lo); rd_reg(2, hi);
        chk("R3 read 0x25", {hi, lo}, 16'h1234);
        chk("R3 read frame", {last_op, last_nb}, {2'b10, 32'(H + 17)});
        wr_reg(3, 8'h07); wr_reg(0, 8'h02); wait_idle();
        rd_reg(1, lo); rd_reg(2, hi);
        chk("R3 read 0x07", {hi, lo}, 16'hA55A);
        wr_reg(3, 8'h3F); wr_reg(0, 8'h02); wait_idle();
        rd_reg(1, lo); rd_reg(2, hi);
        chk("R3 read 0x3F", {hi, lo}, 16'h8001);
        chk("R3 addr sent", last_addr, 6'h3F);

        // R5 factory fence
        wr_reg(1, 8'h11); wr_reg(2, 8'h22);
        wr_reg(3, 8'h0F);
        fc = frame_cnt;
        wr_reg(0, 8'h03);
        rd_reg(0, v); chk("R5 werr on 0x0F", v, 8'h02);
        repeat (4*DIV) @(negedge clk);
        chk("R5 no frame", frame_cnt - fc, 0);
        chk("R5 word untouched", mem[6'h0F], 16'hBEEF);
        // R6 next accepted op clears werr
        wr_reg(0, 8'h02);
        rd_reg(0, v); chk("R6 werr cleared", v[1], 0);
        wait_idle();
        rd_reg(1, lo); rd_reg(2, hi);
        chk("R5 fenced word reads back", {hi, lo}, 16'hBEEF);
        // boundary 0x10 allowed
        wr_reg(3, 8'h10); wr_reg(0, 8'h03); wait_idle();
        rd_reg(0, v); chk("R5 0x10 allowed status", v, 0);
        chk("R5 0x10 written", mem[6'h10], 16'h2211);
        // jumper high opens the fence
        fact_jmp = 1;
        wr_reg(3, 8'h05); wr_reg(0, 8'h03); wait_idle();
        rd_reg(0, v); chk("R5 jumper status", v, 0);
        chk("R5 jumper written", mem[6'h05], 16'h2211);

        // R8 timeout
        rdy_dly = 1000;
        wr_reg(3, 8'h30); wr_reg(0, 8'h03); wait_idle();
        rd_reg(0, v); chk("R8 timeout flag", v, 8'h04);
        rdy_dly = 5;
        wr_reg(0, 8'h02);
        rd_reg(0, v); chk("R6 terr cleared", v, 8'h01);
        wait_idle();

        // R11 unknown codes
        fc = frame_cnt;
        wr_reg(0, 8'h07);
        rd_reg(0, v); chk("R11 code 0x07 ignored", v, 0);
        wr_reg(0, 8'h00);
        rd_reg(0, v); chk("R11 code 0x00 ignored", v, 0);
        repeat (4*DIV) @(negedge clk);
        chk("R11 no frame", frame_cnt - fc, 0);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule